// File: doc/BRIEF.md
# Cache Tag Store with Match Comparator

This block holds the tag directory of a direct-mapped secondary cache. Every entry keeps a tag field together with three status flags: valid, dirty and write-through. The lookup address selects one entry. The block compares the stored tag with a probe tag and returns a hit flag within the same cycle. It also returns the stored tag and flags through separate read ports. These read paths are purely combinational.

Writes to the tag field and to the status field each have their own enable and take effect at the rising clock edge. A synchronous clear input wipes the flags of every entry in one cycle. This invalidates the whole directory at once. Two chip selects allow several stores to be stacked in depth. A power-down input freezes the contents and silences the outputs. A mode input chooses how the flags are used. In cache mode the valid flag qualifies the hit. In user mode the three flags are plain storage and the hit is raw tag equality.

Top module: `tag_lookup_store`

## Requirements
- R1: With the block active (sel1_n low, sel2 high, pwr_down low) and tag_wr_n low at a rising edge, tag_in is stored at addr; that entry's flags are unchanged.
- R2: With the block active and flag_wr_n low at a rising edge, vld_in/dty_in/wt_in are stored at addr; that entry's tag is unchanged.
- R3: tag_out shows the stored tag at addr combinationally while active and tag_rd_n is low, otherwise all zeros; vld_out/dty_out/wt_out behave the same under flag_rd_n, independently of tag_rd_n.
- R4: With user_mode low, hit is high exactly when the block is active, the stored tag at addr equals tag_in and the stored valid flag is 1.
- R5: With user_mode high, hit is high exactly when the block is active and the stored tag equals tag_in, whatever the stored valid flag.
- R6: When either chip select is inactive or pwr_down is high, hit and all read outputs are zero.
- R7: A write attempted while either chip select is inactive leaves the store unchanged.
- R8: A write attempted while pwr_down is high leaves the store unchanged.
- R9: clr_n low at a rising edge clears all three flags of every entry, even if a flag write is requested in the same cycle; stored tags are kept.
- R10: The clear is synchronous: clr_n pulsed low between two rising edges and released before the next edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and clear act on its rising edge |
| clr_n | input | 1 | Synchronous clear of all flags, active low |
| addr | input | ADDR_W | Entry index |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| tag_wr_n | input | 1 | Tag field write enable, active low |
| flag_wr_n | input | 1 | Flag field write enable, active low |
| tag_rd_n | input | 1 | Tag field read enable, active low |
| flag_rd_n | input | 1 | Flag field read enable, active low |
| user_mode | input | 1 | 0 = cache mode (valid gates hit), 1 = user mode |
| pwr_down | input | 1 | Standby: no writes, outputs zero |
| tag_in | input | TAG_W | Write data and compare probe |
| vld_in | input | 1 | Valid flag write data |
| dty_in | input | 1 | Dirty flag write data |
| wt_in | input | 1 | Write-through flag write data |
| tag_out | output | TAG_W | Stored tag read data |
| vld_out | output | 1 | Stored valid flag |
| dty_out | output | 1 | Stored dirty flag |
| wt_out | output | 1 | Stored write-through flag |
| hit | output | 1 | Tag match flag, active high |

## Verification
The clear and a flag write can land on the same edge. The bench therefore drives clr_n low and flag_wr_n low together at an entry that is currently valid. It then reads that entry back and expects all flags zero, with the tag unchanged. A further probe expects hit low in cache mode and high in user mode, which shows that the clear won while the tag array was left alone.

// File: rtl/tagstore_pkg.sv
package tagstore_pkg;

    typedef struct packed {
        logic vld;
        logic dty;
        logic wt;
    } flag_t;

    localparam int FLAG_W = $bits(flag_t);

endpackage

// File: rtl/tag_field_array.sv
module tag_field_array #(
    parameter int ADDR_W = 6,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  wdata,
    output logic [TAG_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0] mem;
    } tag_state_t;

    tag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.mem[addr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata = st_q.mem[addr];

    a_r1_tag_stored: assert property (@(posedge clk) disable iff (!clr_n)
        we |=> ($stable(addr) -> (rdata == $past(wdata))));

endmodule

// File: rtl/flag_field_array.sv
module flag_field_array
    import tagstore_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  flag_t             wdata,
    output flag_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0] vld;
        logic [DEPTH-1:0] dty;
        logic [DEPTH-1:0] wt;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!clr_n) begin
            st_d = '0;
        end else if (we) begin
            st_d.vld[addr] = wdata.vld;
            st_d.dty[addr] = wdata.dty;
            st_d.wt[addr]  = wdata.wt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata.vld = st_q.vld[addr];
    assign rdata.dty = st_q.dty[addr];
    assign rdata.wt  = st_q.wt[addr];

    a_r9_flash_clear: assert property (@(posedge clk)
        !clr_n |=> (rdata == '0));

    a_r2_flag_stored: assert property (@(posedge clk) disable iff (!clr_n)
        we |=> ($stable(addr) && clr_n -> (rdata == $past(wdata))));

endmodule

// File: rtl/tag_compare.sv
module tag_compare #(
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             active,
    input  logic             user_mode,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] probe_tag,
    input  logic             stored_vld,
    output logic             hit
);
    logic tags_equal;
    logic qualifier;

    always_comb begin
        tags_equal = (stored_tag == probe_tag);
        qualifier  = user_mode | stored_vld;
        hit        = active & tags_equal & qualifier;
    end

    a_r4_valid_gates_hit: assert property (@(posedge clk) disable iff (!clr_n)
        (hit && !user_mode) |-> stored_vld);

    a_r6_idle_no_hit: assert property (@(posedge clk) disable iff (!clr_n)
        !active |-> !hit);

endmodule

// File: rtl/tag_lookup_store.sv
module tag_lookup_store
    import tagstore_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              tag_wr_n,
    input  logic              flag_wr_n,
    input  logic              tag_rd_n,
    input  logic              flag_rd_n,
    input  logic              user_mode,
    input  logic              pwr_down,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic              vld_in,
    input  logic              dty_in,
    input  logic              wt_in,
    output logic [TAG_W-1:0]  tag_out,
    output logic              vld_out,
    output logic              dty_out,
    output logic              wt_out,
    output logic              hit
);
    logic             active;
    logic             tag_we;
    logic             flag_we;
    logic [TAG_W-1:0] tag_rd;
    flag_t            flag_wd;
    flag_t            flag_rd;
    flag_t            flag_vis;

    always_comb begin
        active  = !sel1_n && sel2 && !pwr_down;
        tag_we  = active && !tag_wr_n;
        flag_we = active && !flag_wr_n;
        flag_wd = '{vld: vld_in, dty: dty_in, wt: wt_in};
    end

    tag_field_array #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_tags (
        .clk   (clk),
        .clr_n (clr_n),
        .we    (tag_we),
        .addr  (addr),
        .wdata (tag_in),
        .rdata (tag_rd)
    );

    flag_field_array #(.ADDR_W(ADDR_W)) u_flags (
        .clk   (clk),
        .clr_n (clr_n),
        .we    (flag_we),
        .addr  (addr),
        .wdata (flag_wd),
        .rdata (flag_rd)
    );

    tag_compare #(.TAG_W(TAG_W)) u_cmp (
        .clk        (clk),
        .clr_n      (clr_n),
        .active     (active),
        .user_mode  (user_mode),
        .stored_tag (tag_rd),
        .probe_tag  (tag_in),
        .stored_vld (flag_rd.vld),
        .hit        (hit)
    );

    always_comb begin
        tag_out  = (active && !tag_rd_n) ? tag_rd : '0;
        flag_vis = (active && !flag_rd_n) ? flag_rd : '0;
        vld_out  = flag_vis.vld;
        dty_out  = flag_vis.dty;
        wt_out   = flag_vis.wt;
    end

    a_r8_standby_holds: assert property (@(posedge clk) disable iff (!clr_n)
        pwr_down |=> ($stable(addr) -> ($stable(tag_rd) && $stable(flag_rd))));

    a_r7_deselect_holds: assert property (@(posedge clk) disable iff (!clr_n)
        (sel1_n || !sel2) |=> ($stable(addr) -> ($stable(tag_rd) && $stable(flag_rd))));

    a_r6_outputs_quiet: assert property (@(posedge clk) disable iff (!clr_n)
        pwr_down |-> (tag_out == '0 && !vld_out && !dty_out && !wt_out && !hit));

endmodule

// File: tb/tag_lookup_store_tb.sv
module tag_lookup_store_tb;
    localparam int AW = 6;
    localparam int TW = 12;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          clr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          sel1_n = 1'b0, sel2 = 1'b1;
    logic          tag_wr_n = 1'b1, flag_wr_n = 1'b1;
    logic          tag_rd_n = 1'b0, flag_rd_n = 1'b0;
    logic          user_mode = 1'b0, pwr_down = 1'b0;
    logic [TW-1:0] tag_in = '0;
    logic          vld_in = 1'b0, dty_in = 1'b0, wt_in = 1'b0;
    logic [TW-1:0] tag_out;
    logic          vld_out, dty_out, wt_out, hit;

    int checks = 0;
    int fails  = 0;
    logic [TW-1:0] m_tag [DEPTH];
    logic [2:0]    m_flg [DEPTH];

    always #10 clk = ~clk;

    tag_lookup_store #(.ADDR_W(AW), .TAG_W(TW)) u_dut (
        .clk(clk), .clr_n(clr_n), .addr(addr), .sel1_n(sel1_n), .sel2(sel2),
        .tag_wr_n(tag_wr_n), .flag_wr_n(flag_wr_n), .tag_rd_n(tag_rd_n),
        .flag_rd_n(flag_rd_n), .user_mode(user_mode), .pwr_down(pwr_down),
        .tag_in(tag_in), .vld_in(vld_in), .dty_in(dty_in), .wt_in(wt_in),
        .tag_out(tag_out), .vld_out(vld_out), .dty_out(dty_out),
        .wt_out(wt_out), .hit(hit)
    );

    // kind: 0 tag write, 1 flag write, 2 probe; st = {vld,dty,wt}
    typedef struct packed {
        logic [1:0]    kind;
        logic [AW-1:0] addr;
        logic [TW-1:0] tag;
        logic [2:0]    st;
        logic          mode;
        logic          exp_hit;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 6'd5,  12'hABC, 3'b000, 1'b0, 1'b0},
        '{2'd1, 6'd5,  12'h000, 3'b100, 1'b0, 1'b0},
        '{2'd2, 6'd5,  12'hABC, 3'b000, 1'b0, 1'b1},
        '{2'd2, 6'd5,  12'hABD, 3'b000, 1'b0, 1'b0},
        '{2'd1, 6'd5,  12'h000, 3'b011, 1'b0, 1'b0},
        '{2'd2, 6'd5,  12'hABC, 3'b000, 1'b0, 1'b0},
        '{2'd2, 6'd5,  12'hABC, 3'b000, 1'b1, 1'b1},
        '{2'd0, 6'd63, 12'hFFF, 3'b000, 1'b0, 1'b0},
        '{2'd1, 6'd63, 12'h000, 3'b110, 1'b0, 1'b0},
        '{2'd2, 6'd63, 12'hFFF, 3'b000, 1'b0, 1'b1},
        '{2'd2, 6'd0,  12'hFFF, 3'b000, 1'b0, 1'b0},
        '{2'd1, 6'd5,  12'h000, 3'b101, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_tag(input logic [AW-1:0] a, input logic [TW-1:0] t);
        addr = a; tag_in = t; tag_wr_n = 1'b0;
        edge_step();
        tag_wr_n = 1'b1;
    endtask

    task automatic wr_flag(input logic [AW-1:0] a, input logic [2:0] s);
        addr = a; {vld_in, dty_in, wt_in} = s; flag_wr_n = 1'b0;
        edge_step();
        flag_wr_n = 1'b1;
    endtask

    task automatic probe(input logic [AW-1:0] a, input logic [TW-1:0] t, input logic m);
        addr = a; tag_in = t; user_mode = m;
        #1;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        clr_n = 1'b0;
        edge_step();
        clr_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            wr_tag(i[AW-1:0], '0);
            m_tag[i] = '0;
            m_flg[i] = '0;
        end

        // R9 reset state: all flags clear after the clear edge
        probe(6'd17, '0, 1'b0);
        chk({vld_out, dty_out, wt_out} == 3'b000, "R9 reset flags", {vld_out, dty_out, wt_out}, 0);
        chk(hit == 1'b0, "R4 no hit on invalid entry", hit, 0);

        // vector table: R1 R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            case (VECS[v].kind)
                2'd0: begin
                    wr_tag(VECS[v].addr, VECS[v].tag);
                    m_tag[VECS[v].addr] = VECS[v].tag;
                end
                2'd1: begin
                    wr_flag(VECS[v].addr, VECS[v].st);
                    m_flg[VECS[v].addr] = VECS[v].st;
                end
                default: begin
                    probe(VECS[v].addr, VECS[v].tag, VECS[v].mode);
                    chk(hit == VECS[v].exp_hit, VECS[v].mode ? "R5 hit" : "R4 hit", hit, VECS[v].exp_hit);
                    chk(tag_out == m_tag[VECS[v].addr], "R1 tag read", tag_out, m_tag[VECS[v].addr]);
                    chk({vld_out, dty_out, wt_out} == m_flg[VECS[v].addr], "R2 flag read",
                        {vld_out, dty_out, wt_out}, m_flg[VECS[v].addr]);
                end
            endcase
        end
        user_mode = 1'b0;

        // R1 / R2 field independence at entry 5 (tag ABC, flags 101)
        wr_tag(6'd5, 12'h123);
        probe(6'd5, 12'h123, 1'b0);
        chk({vld_out, dty_out, wt_out} == 3'b101, "R1 flags kept on tag write", {vld_out, dty_out, wt_out}, 3'b101);
        chk(hit == 1'b1, "R4 hit after tag rewrite", hit, 1);
        wr_flag(6'd5, 3'b110);
        probe(6'd5, 12'h123, 1'b0);
        chk(tag_out == 12'h123, "R2 tag kept on flag write", tag_out, 12'h123);

        // R3 independent read enables
        tag_rd_n = 1'b1; #1;
        chk(tag_out == '0, "R3 tag read disabled", tag_out, 0);
        chk({vld_out, dty_out, wt_out} == 3'b110, "R3 flag read still on", {vld_out, dty_out, wt_out}, 3'b110);
        tag_rd_n = 1'b0; flag_rd_n = 1'b1; #1;
        chk(tag_out == 12'h123, "R3 tag read on", tag_out, 12'h123);
        chk({vld_out, dty_out, wt_out} == 3'b000, "R3 flag read disabled", {vld_out, dty_out, wt_out}, 0);
        flag_rd_n = 1'b0;

        // R6 deselect and standby silence outputs
        sel1_n = 1'b1; #1;
        chk(hit == 1'b0 && tag_out == '0, "R6 sel1 inactive", {hit, tag_out}, 0);
        sel1_n = 1'b0; sel2 = 1'b0; #1;
        chk(hit == 1'b0 && vld_out == 1'b0, "R6 sel2 inactive", {hit, vld_out}, 0);
        sel2 = 1'b1; pwr_down = 1'b1; #1;
        chk(hit == 1'b0 && tag_out == '0 && vld_out == 1'b0, "R6 standby", {hit, tag_out, vld_out}, 0);
        pwr_down = 1'b0;

        // R7 writes while deselected are dropped
        sel1_n = 1'b1; wr_tag(6'd5, 12'h777); wr_flag(6'd5, 3'b000);
        sel1_n = 1'b0; sel2 = 1'b0; wr_tag(6'd5, 12'h777);
        sel2 = 1'b1;
        probe(6'd5, 12'h123, 1'b0);
        chk(tag_out == 12'h123, "R7 tag unchanged", tag_out, 12'h123);
        chk({vld_out, dty_out, wt_out} == 3'b110, "R7 flags unchanged", {vld_out, dty_out, wt_out}, 3'b110);

        // R8 writes in standby are dropped
        pwr_down = 1'b1; wr_tag(6'd5, 12'h555); wr_flag(6'd5, 3'b001);
        pwr_down = 1'b0;
        probe(6'd5, 12'h123, 1'b0);
        chk(tag_out == 12'h123, "R8 tag unchanged", tag_out, 12'h123);
        chk({vld_out, dty_out, wt_out} == 3'b110, "R8 flags unchanged", {vld_out, dty_out, wt_out}, 3'b110);

        // R10 clear pulse between edges has no effect
        @(posedge clk); #3; clr_n = 1'b0; #4; clr_n = 1'b1;
        @(negedge clk);
        probe(6'd5, 12'h123, 1'b0);
        chk(vld_out == 1'b1, "R10 glitch ignored", vld_out, 1);

        // R9 clear beats a same-cycle flag write, tags kept
        addr = 6'd5; {vld_in, dty_in, wt_in} = 3'b111; flag_wr_n = 1'b0; clr_n = 1'b0;
        edge_step();
        flag_wr_n = 1'b1; clr_n = 1'b1;
        probe(6'd5, 12'h123, 1'b0);
        chk({vld_out, dty_out, wt_out} == 3'b000, "R9 clear wins", {vld_out, dty_out, wt_out}, 0);
        chk(tag_out == 12'h123, "R9 tag kept", tag_out, 12'h123);
        chk(hit == 1'b0, "R4 hit gated after clear", hit, 0);
        probe(6'd5, 12'h123, 1'b1);
        chk(hit == 1'b1, "R5 raw match after clear", hit, 1);
        probe(6'd63, 12'hFFF, 1'b0);
        chk(vld_out == 1'b0 && hit == 1'b0, "R9 other entry cleared", {vld_out, hit}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule